// File: doc/BRIEF.md
# Serial Port Interrupt Status Generator

This block collects the four interrupt conditions of a synchronous serial port that has a transmit FIFO and a receive FIFO. It watches the FIFO occupancy counts, a strobe for each completed received frame, a strobe for each read from the receive FIFO, and a tick that marks one serial bit period. A bit period is the peripheral clock divided by the prescaler times (clock-rate setting + 1). From these inputs it produces raw status, masked status and a single interrupt line. It also holds an enable register and accepts write-one-to-clear commands.

Two of the conditions are sticky and stay set until software clears them: receive overrun and receive timeout. The other two follow the FIFO levels directly: receive at least half full and transmit at least half empty. The timeout is timed by a small state machine whose states are named in the requirements. TO_IDLE means the receive FIFO is empty and the counter is held at zero. TO_COUNT counts bit ticks while the FIFO holds data. TO_EXPIRED is entered after the limit is reached and stays there until the FIFO is read or drained.

The state machine has these transitions:
- TO_IDLE to TO_COUNT when the FIFO becomes non-empty.
- TO_COUNT to TO_IDLE when the FIFO empties.
- TO_COUNT to TO_EXPIRED on the 32nd tick with no read.
- TO_EXPIRED to TO_COUNT on a read while data remains.
- TO_EXPIRED to TO_IDLE when the FIFO empties.

The timing is the same whether the port runs as master or as slave.

Top module: `sport_irq_status`

## Requirements
- R1: Raw bit 0 (overrun) sets on the clock edge where `rx_frame_done` is high and `rx_count` equals the FIFO depth (8). It stays set until it is cleared. A frame that arrives while the FIFO is below depth does not set it.
- R2: Raw bit 1 (timeout) sets on the edge of the 32nd `bit_tick` counted in TO_COUNT with no receive read in between. After 31 such ticks it is still clear. A tick in the same cycle as the TO_IDLE to TO_COUNT transition is not counted.
- R3: A pulse on `rx_pop` restarts the count from zero. An empty receive FIFO sends the machine to TO_IDLE, where the count is held at zero.
- R4: Raw bit 2 is high exactly when `rx_count` is at least 4 (half of depth 8).
- R5: Raw bit 3 is high exactly when `tx_count` is at most 4.
- R6: `masked_status` bits 3:0 equal the raw bits ANDed with the enable register, in the order overrun, timeout, receive level, transmit level. Bits 31:4 are zero. A `mask_wr` pulse loads `mask_wdata` into the enable register, which reads back on `mask_q` from the next cycle.
- R7: A `clr_wr` pulse clears overrun when `clr_wdata` bit 0 is 1 and clears timeout when `clr_wdata` bit 1 is 1. A zero in either bit leaves that flag unchanged.
- R8: Clear writes have no effect on raw bits 2 and 3.
- R9: When a set condition and a clear for the same sticky flag occur in one cycle, the flag ends up set.
- R10: `irq` is the OR of `masked_status` bits 3:0.
- R11: During and right after reset, both sticky flags and the enable register are zero.
- R12: One expiry sets the timeout flag once. If the flag is cleared while in TO_EXPIRED, it stays clear until a read restarts TO_COUNT and another 32 ticks pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_count | input | 4 | Receive FIFO occupancy |
| tx_count | input | 4 | Transmit FIFO occupancy |
| rx_frame_done | input | 1 | One-cycle pulse per completed received frame |
| rx_pop | input | 1 | One-cycle pulse per receive FIFO read |
| bit_tick | input | 1 | One-cycle pulse per serial bit period |
| mask_wr | input | 1 | Enable register write strobe |
| mask_wdata | input | 4 | Enable register write data |
| clr_wr | input | 1 | Clear command strobe |
| clr_wdata | input | 2 | Clear command bits (bit 0 overrun, bit 1 timeout) |
| raw_status | output | 4 | Unmasked condition bits |
| masked_status | output | 32 | Enabled condition bits, upper 28 bits zero |
| mask_q | output | 4 | Enable register contents |
| irq | output | 1 | Combined interrupt |

## Verification
The level and masking path is driven through a table of occupancy and enable combinations. The table covers counts on both sides of the half-depth threshold, with all, some or none of the sources enabled. This separates an off-by-one threshold from a wrong bit position or a missing AND with the enable.

The timeout path is tried with the following patterns:
- an uninterrupted run of ticks, checked at 31 and at 32;
- a run broken by a read;
- a run broken by the FIFO emptying;
- a long run after a clear while in TO_EXPIRED.

These show whether the count limit, the restart and the hold-at-zero are right, and whether the flag re-arms only after an expiry. Coincident set and clear, and clears with a zero bit, separate set priority from clear decoding.

// File: rtl/sport_irq_pkg.sv
package sport_irq_pkg;

    typedef enum logic [1:0] {
        TO_IDLE    = 2'd0,
        TO_COUNT   = 2'd1,
        TO_EXPIRED = 2'd2
    } to_state_e;

    localparam int SRC_OVR  = 0;
    localparam int SRC_TO   = 1;
    localparam int SRC_RXL  = 2;
    localparam int SRC_TXL  = 3;
    localparam int NUM_SRC  = 4;
    localparam int NUM_STICKY = 2;
    localparam int STAT_W   = 32;

endpackage

// File: rtl/sport_to_timer.sv
module sport_to_timer
    import sport_irq_pkg::*;
#(
    parameter int TIMEOUT_BITS = 32,
    parameter int CNT_W        = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             rx_pop,
    input  logic             bit_tick,
    output logic             to_event
);
    localparam int TO_W = (TIMEOUT_BITS > 1) ? $clog2(TIMEOUT_BITS) : 1;
    localparam logic [TO_W-1:0] LAST = TO_W'(TIMEOUT_BITS - 1);

    to_state_e       st_q, st_n;
    logic [TO_W-1:0] cnt_q, cnt_n;
    logic            rx_empty;

    assign rx_empty = (rx_count == '0);

    // state and counter registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= TO_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
        end
    end

    // output decode
    always_comb begin
        to_event = 1'b0;
        unique case (st_q)
            TO_COUNT: to_event = !rx_empty && !rx_pop && bit_tick && (cnt_q == LAST);
            default:  to_event = 1'b0;
        endcase
    end

    // next state
    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        unique case (st_q)
            TO_IDLE: begin
                cnt_n = '0;
                if (!rx_empty) st_n = TO_COUNT;
            end
            TO_COUNT: begin
                if (rx_empty) begin
                    st_n  = TO_IDLE;
                    cnt_n = '0;
                end else if (rx_pop) begin
                    cnt_n = '0;
                end else if (to_event) begin
                    st_n  = TO_EXPIRED;
                    cnt_n = '0;
                end else if (bit_tick) begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            TO_EXPIRED: begin
                cnt_n = '0;
                if (rx_empty)    st_n = TO_IDLE;
                else if (rx_pop) st_n = TO_COUNT;
            end
            default: begin
                st_n  = TO_IDLE;
                cnt_n = '0;
            end
        endcase
    end

endmodule

// File: rtl/sport_sticky_flag.sv
module sport_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= 1'b0;
        else if (set_i) q <= 1'b1;
        else if (clr_i) q <= 1'b0;
    end
endmodule

// File: rtl/sport_level_flags.sv
module sport_level_flags #(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] tx_count,
    output logic             rx_half_full,
    output logic             tx_half_empty
);
    localparam logic [CNT_W-1:0] HALF = CNT_W'(DEPTH / 2);

    assign rx_half_full  = (rx_count >= HALF);
    assign tx_half_empty = (tx_count <= HALF);
endmodule

// File: rtl/sport_irq_status.sv
module sport_irq_status
    import sport_irq_pkg::*;
#(
    parameter int DEPTH        = 8,
    parameter int TIMEOUT_BITS = 32,
    parameter int CNT_W        = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CNT_W-1:0]      rx_count,
    input  logic [CNT_W-1:0]      tx_count,
    input  logic                  rx_frame_done,
    input  logic                  rx_pop,
    input  logic                  bit_tick,
    input  logic                  mask_wr,
    input  logic [NUM_SRC-1:0]    mask_wdata,
    input  logic                  clr_wr,
    input  logic [NUM_STICKY-1:0] clr_wdata,
    output logic [NUM_SRC-1:0]    raw_status,
    output logic [STAT_W-1:0]     masked_status,
    output logic [NUM_SRC-1:0]    mask_q,
    output logic                  irq
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [NUM_STICKY-1:0] sticky_set;
    logic [NUM_STICKY-1:0] sticky_q;
    logic                  to_event;
    logic                  rx_lvl, tx_lvl;

    sport_to_timer #(
        .TIMEOUT_BITS (TIMEOUT_BITS),
        .CNT_W        (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_count (rx_count),
        .rx_pop   (rx_pop),
        .bit_tick (bit_tick),
        .to_event (to_event)
    );

    sport_level_flags #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) u_levels (
        .rx_count      (rx_count),
        .tx_count      (tx_count),
        .rx_half_full  (rx_lvl),
        .tx_half_empty (tx_lvl)
    );

    assign sticky_set[SRC_OVR] = rx_frame_done && (rx_count == FULL);
    assign sticky_set[SRC_TO]  = to_event;

    for (genvar i = 0; i < NUM_STICKY; i++) begin : g_sticky
        sport_sticky_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (sticky_set[i]),
            .clr_i (clr_wr && clr_wdata[i]),
            .q     (sticky_q[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_wr) mask_q <= mask_wdata;
    end

    assign raw_status[SRC_OVR] = sticky_q[SRC_OVR];
    assign raw_status[SRC_TO]  = sticky_q[SRC_TO];
    assign raw_status[SRC_RXL] = rx_lvl;
    assign raw_status[SRC_TXL] = tx_lvl;

    for (genvar b = 0; b < STAT_W; b++) begin : g_mis
        if (b < NUM_SRC) begin : g_src
            assign masked_status[b] = raw_status[b] & mask_q[b];
        end else begin : g_rsv
            assign masked_status[b] = 1'b0;
        end
    end

    assign irq = |masked_status[NUM_SRC-1:0];

endmodule

// File: rtl/sport_irq_status_chk.sv
module sport_irq_status_chk
    import sport_irq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [CNT_W-1:0]      rx_count,
    input logic                  rx_frame_done,
    input logic                  clr_wr,
    input logic [NUM_STICKY-1:0] clr_wdata,
    input logic [NUM_SRC-1:0]    raw_status,
    input logic [STAT_W-1:0]     masked_status,
    input logic [NUM_SRC-1:0]    mask_q,
    input logic                  irq
);
    logic ovr_evt;
    assign ovr_evt = rx_frame_done && (rx_count == CNT_W'(DEPTH));

    p_ovr_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_evt |=> raw_status[SRC_OVR]);

    p_ovr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_status[SRC_OVR] && !(clr_wr && clr_wdata[SRC_OVR])) |=> raw_status[SRC_OVR]);

    p_ovr_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_wdata[SRC_OVR] && !ovr_evt) |=> !raw_status[SRC_OVR]);

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_wdata[SRC_OVR] && ovr_evt) |=> raw_status[SRC_OVR]);

    p_to_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_status[SRC_TO] && !(clr_wr && clr_wdata[SRC_TO])) |=> raw_status[SRC_TO]);

    p_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (masked_status[STAT_W-1:NUM_SRC] == '0) &&
        ((masked_status[NUM_SRC-1:0] & ~mask_q) == '0));

    p_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (masked_status != '0));

    p_rst_r11: assert property (@(posedge clk)
        $rose(rst_n) |-> (raw_status[1:0] == 2'b00) && (mask_q == '0));
endmodule

bind sport_irq_status sport_irq_status_chk #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_count      (rx_count),
    .rx_frame_done (rx_frame_done),
    .clr_wr        (clr_wr),
    .clr_wdata     (clr_wdata),
    .raw_status    (raw_status),
    .masked_status (masked_status),
    .mask_q        (mask_q),
    .irq           (irq)
);

// File: tb/sport_irq_status_tb.sv
module sport_irq_status_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rx_count = '0;
    logic [3:0]  tx_count = 4'd8;
    logic        rx_frame_done = 1'b0;
    logic        rx_pop = 1'b0;
    logic        bit_tick = 1'b0;
    logic        mask_wr = 1'b0;
    logic [3:0]  mask_wdata = '0;
    logic        clr_wr = 1'b0;
    logic [1:0]  clr_wdata = '0;
    logic [3:0]  raw_status;
    logic [31:0] masked_status;
    logic [3:0]  mask_q;
    logic        irq;

    int n_checks = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    sport_irq_status u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_count      (rx_count),
        .tx_count      (tx_count),
        .rx_frame_done (rx_frame_done),
        .rx_pop        (rx_pop),
        .bit_tick      (bit_tick),
        .mask_wr       (mask_wr),
        .mask_wdata    (mask_wdata),
        .clr_wr        (clr_wr),
        .clr_wdata     (clr_wdata),
        .raw_status    (raw_status),
        .masked_status (masked_status),
        .mask_q        (mask_q),
        .irq           (irq)
    );

    // {rx_count, tx_count, mask, exp {txlvl,rxlvl}, exp masked[3:0]}
    localparam logic [17:0] VEC [8] = '{
        {4'd0, 4'd8, 4'b1111, 2'b00, 4'b0000},
        {4'd3, 4'd5, 4'b1111, 2'b00, 4'b0000},
        {4'd4, 4'd5, 4'b1111, 2'b01, 4'b0100},
        {4'd8, 4'd4, 4'b1111, 2'b11, 4'b1100},
        {4'd8, 4'd4, 4'b0100, 2'b11, 4'b0100},
        {4'd8, 4'd4, 4'b0000, 2'b11, 4'b0000},
        {4'd2, 4'd0, 4'b1000, 2'b10, 4'b1000},
        {4'd7, 4'd3, 4'b0011, 2'b11, 4'b0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            bit_tick = 1'b1;
            @(negedge clk);
            bit_tick = 1'b0;
        end
    endtask

    task automatic pulse_clr(input logic [1:0] d);
        clr_wr = 1'b1; clr_wdata = d;
        @(negedge clk);
        clr_wr = 1'b0; clr_wdata = '0;
    endtask

    task automatic pulse_pop();
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    initial begin
        // R11: reset state
        cyc(3);
        chk("R11 raw in reset", {28'd0, raw_status}, 32'd0);
        chk("R11 mask in reset", {28'd0, mask_q}, 32'd0);
        chk("R10 irq in reset", {31'd0, irq}, 32'd0);
        rst_n = 1'b1;
        cyc(2);
        chk("R11 raw after reset", {28'd0, raw_status}, 32'd0);

        // table: R4, R5, R6, R10
        for (int v = 0; v < 8; v++) begin
            rx_count   = VEC[v][17:14];
            tx_count   = VEC[v][13:10];
            mask_wr    = 1'b1;
            mask_wdata = VEC[v][9:6];
            @(negedge clk);
            mask_wr = 1'b0;
            chk("R6 mask readback", {28'd0, mask_q}, {28'd0, VEC[v][9:6]});
            chk("R4 R5 level bits", {30'd0, raw_status[3:2]}, {30'd0, VEC[v][5:4]});
            chk("R6 masked status", masked_status, {28'd0, VEC[v][3:0]});
            chk("R10 irq", {31'd0, irq}, {31'd0, |VEC[v][3:0]});
        end

        // enable all, empty rx, clean start
        rx_count = 4'd0; tx_count = 4'd8;
        mask_wr = 1'b1; mask_wdata = 4'b1111;
        cyc(1);
        mask_wr = 1'b0;
        cyc(2);

        // R1: frame at 7 entries no overrun, at 8 sets
        rx_count = 4'd7; rx_frame_done = 1'b1;
        cyc(1);
        rx_frame_done = 1'b0;
        chk("R1 no overrun below full", {31'd0, raw_status[0]}, 32'd0);
        rx_count = 4'd8; rx_frame_done = 1'b1;
        cyc(1);
        rx_frame_done = 1'b0;
        chk("R1 overrun set at full", {31'd0, raw_status[0]}, 32'd1);
        cyc(3);
        chk("R1 overrun sticky", {31'd0, raw_status[0]}, 32'd1);
        chk("R10 irq with overrun", {31'd0, irq}, 32'd1);
        // R7 zero bit leaves it, R8 levels untouched
        pulse_clr(2'b10);
        chk("R7 zero bit no effect", {31'd0, raw_status[0]}, 32'd1);
        chk("R8 levels untouched", {30'd0, raw_status[3:2]}, 32'd1);
        // R9 set wins
        rx_frame_done = 1'b1;
        pulse_clr(2'b01);
        rx_frame_done = 1'b0;
        chk("R9 set wins over clear", {31'd0, raw_status[0]}, 32'd1);
        pulse_clr(2'b11);
        chk("R7 overrun cleared", {31'd0, raw_status[0]}, 32'd0);
        chk("R8 levels after clear", {30'd0, raw_status[3:2]}, 32'd1);
        rx_count = 4'd0;
        cyc(3);

        // R2: 31 ticks no, 32 yes
        rx_count = 4'd1;
        cyc(2);
        ticks(31);
        chk("R2 no timeout after 31", {31'd0, raw_status[1]}, 32'd0);
        ticks(1);
        chk("R2 timeout after 32", {31'd0, raw_status[1]}, 32'd1);
        pulse_clr(2'b01);
        chk("R7 zero bit keeps timeout", {31'd0, raw_status[1]}, 32'd1);
        pulse_clr(2'b10);
        chk("R7 timeout cleared", {31'd0, raw_status[1]}, 32'd0);

        // R12: no re-set without a read
        ticks(40);
        chk("R12 no re-arm without read", {31'd0, raw_status[1]}, 32'd0);
        pulse_pop();
        ticks(31);
        chk("R12 not yet after read", {31'd0, raw_status[1]}, 32'd0);
        ticks(1);
        chk("R12 re-set after read and 32", {31'd0, raw_status[1]}, 32'd1);
        pulse_clr(2'b10);

        // R3: read restarts count
        pulse_pop();
        ticks(20);
        pulse_pop();
        ticks(31);
        chk("R3 read restarts count", {31'd0, raw_status[1]}, 32'd0);
        ticks(1);
        chk("R3 timeout after restart", {31'd0, raw_status[1]}, 32'd1);
        pulse_clr(2'b10);

        // R3: empty fifo holds count at zero
        pulse_pop();
        ticks(20);
        rx_count = 4'd0;
        cyc(1);
        ticks(10);
        rx_count = 4'd1;
        cyc(2);
        ticks(31);
        chk("R3 empty holds zero", {31'd0, raw_status[1]}, 32'd0);
        ticks(1);
        chk("R3 timeout after refill", {31'd0, raw_status[1]}, 32'd1);

        // R6 masking hides the sticky flag
        mask_wr = 1'b1; mask_wdata = 4'b0000;
        cyc(1);
        mask_wr = 1'b0;
        chk("R6 masked off", masked_status, 32'd0);
        chk("R10 irq masked off", {31'd0, irq}, 32'd0);

        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end
endmodule